// File: doc/BRIEF.md
# Counter-Group Configuration Read Gate

This block decides what happens when software reads one of two 64-bit counter-group configuration words belonging to a selected monitoring unit. It takes the decoded register-access fields, the privilege level of the requester (0 to 3), a unit index, and the state of the higher privilege levels. That state is which levels exist and are active, their per-level enables, their 2-bit per-unit permission fields, and the fine-grained trap controls. From these it produces exactly one outcome: undefined instruction, trap to level 2, trap to level 3, or a successful read that carries the 64-bit word.

Each word holds eight byte-wide counts. Byte m of word n gives the number of counters in group 8n+m. A plain write port loads the words. Results are registered and appear one clock after the access is presented. The word storage has a synchronous read so that block RAM can hold it.

Top module: `sysreg_grpcfg_gate`

## Requirements
- R1: An access produces a result only when acc_valid is high and the fields are op0=2'b10, op1=3'b000, CRn=4'b1001, CRm=4'b1101 and op2[2:1]=2'b00. Any other access leaves res_valid and all four outcome outputs low on the following cycle.
- R2: op2[0] selects word 0 or word 1 of the unit. On a successful read, res_data returns the stored word, in which byte m sits at bits 8m+7:8m. res_data is zero for every other outcome.
- R3: An access from level 0 is always undefined.
- R4: An access from level 3 always succeeds and returns the selected word.
- R5: At level 1 or level 2, when level 3 exists and undef_prio is high, the access is undefined if el3_unit_en is low. Otherwise it is undefined if the level-3 permission field of the unit is 2'b00. Both checks take precedence over every trap.
- R6: At level 1 only, and only when el2_active is high, these conditions trap to level 2, tested in this order. First: fg_trap_impl is high and either fg_read_allow is low or fg_el3_en is low while level 3 exists. Second: el2_unit_en is low. Third: the level-2 permission field is 2'b00. At level 2 none of these conditions applies.
- R7: After the R5 and R6 checks, when level 3 exists, a low el3_unit_en or a level-3 permission field of 2'b00 makes the access undefined if undef_not_trap is high. Otherwise it traps to level 3. If no condition fires, the read succeeds.
- R8: The permission field of unit s is bits 2s+1:2s of el2_perm or el3_perm. Only the value 2'b00 denies access. The values 01, 10 and 11 all allow it.
- R9: When res_valid is high, exactly one of res_undef, res_trap_l2, res_trap_l3 and res_ok is high. res_class is 6'h18 on a trap and zero otherwise.
- R10: A unit index of NUM_UNITS or more reads data zero. The permission checks still apply to it as normal.
- R11: All results appear on the cycle after the access. A synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for a configuration word |
| cfg_unit | input | SEL_W | Unit written by the load |
| cfg_reg | input | 1 | Word index written by the load |
| cfg_wdata | input | 64 | Word value to load |
| acc_valid | input | 1 | Read access present |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2; bit 0 selects the word |
| acc_lvl | input | 2 | Privilege level of the requester |
| acc_unit | input | SEL_W | Selected unit index |
| has_el3 | input | 1 | Level 3 exists |
| el2_active | input | 1 | Level 2 is enabled |
| undef_prio | input | 1 | Level-3 denials take priority as undefined |
| undef_not_trap | input | 1 | Late level-3 denials are undefined rather than trapped |
| el3_unit_en | input | 1 | Level-3 enable for monitoring-unit access |
| el2_unit_en | input | 1 | Level-2 enable for monitoring-unit access |
| fg_trap_impl | input | 1 | Fine-grained trap feature present |
| fg_el3_en | input | 1 | Level-3 enable of the fine-grained traps |
| fg_read_allow | input | 1 | Fine-grained read-permit bit for this register |
| el2_perm | input | 2*2**SEL_W | Level-2 permission fields, 2 bits per unit |
| el3_perm | input | 2*2**SEL_W | Level-3 permission fields, 2 bits per unit |
| res_valid | output | 1 | Result present |
| res_undef | output | 1 | Outcome: undefined |
| res_trap_l2 | output | 1 | Outcome: trap to level 2 |
| res_trap_l3 | output | 1 | Outcome: trap to level 3 |
| res_ok | output | 1 | Outcome: successful read |
| res_class | output | 6 | Syndrome class of a trap |
| res_data | output | 64 | Read data |

## Verification
Every result, including the read data from the synchronous store, is due exactly one rising edge after the access is presented. The bench drives each access on a falling edge and samples all outputs 1 time unit after the next rising edge. Each vector is therefore checked alone, before the next vector replaces it. The sweep covers all four levels, all 512 combinations of the nine control flags, and each allow/deny pair of permission fields. For each vector the unit and word index rotate, and the neighbouring permission fields hold the opposite verdict, so that a wrongly indexed field shows up.

// File: rtl/sysreg_grpcfg_pkg.sv
package sysreg_grpcfg_pkg;
  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_UNDEF = 2'd1,
    RES_TRAP2 = 2'd2,
    RES_TRAP3 = 2'd3
  } res_kind_e;

  typedef struct packed {
    logic has_el3;
    logic el2_active;
    logic undef_prio;
    logic undef_not_trap;
    logic el3_unit_en;
    logic el2_unit_en;
    logic fg_trap_impl;
    logic fg_el3_en;
    logic fg_read_allow;
  } gate_ctl_t;

  localparam logic [5:0] TRAP_CLASS = 6'h18;
  localparam int unsigned WORD_W = 64;
endpackage

// File: rtl/grpcfg_enc_match.sv
module grpcfg_enc_match (
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit,
  output logic       word_sel
);
  always_comb begin
    hit      = (op0 == 2'b10) && (op1 == 3'b000) && (crn == 4'b1001) &&
               (crm == 4'b1101) && (op2[2:1] == 2'b00);
    word_sel = op2[0];
  end
endmodule

// File: rtl/grpcfg_priv_chain.sv
module grpcfg_priv_chain
  import sysreg_grpcfg_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic [1:0]             lvl,
  input  logic [SEL_W-1:0]       unit,
  input  gate_ctl_t              ctl,
  input  logic [2*(2**SEL_W)-1:0] el2_perm,
  input  logic [2*(2**SEL_W)-1:0] el3_perm,
  output res_kind_e              kind
);
  logic [1:0] f2, f3;
  logic       l3_deny, l2_fg_trap, l2_check;

  always_comb begin
    f2         = el2_perm[{unit, 1'b0} +: 2];
    f3         = el3_perm[{unit, 1'b0} +: 2];
    l3_deny    = !ctl.el3_unit_en || (f3 == 2'b00);
    l2_check   = (lvl == 2'd1) && ctl.el2_active;
    l2_fg_trap = ctl.fg_trap_impl &&
                 ((ctl.has_el3 && !ctl.fg_el3_en) || !ctl.fg_read_allow);
    kind = RES_OK;
    if (lvl == 2'd0)
      kind = RES_UNDEF;
    else if (lvl == 2'd3)
      kind = RES_OK;
    else if (ctl.has_el3 && ctl.undef_prio && l3_deny)
      kind = RES_UNDEF;
    else if (l2_check && (l2_fg_trap || !ctl.el2_unit_en || (f2 == 2'b00)))
      kind = RES_TRAP2;
    else if (ctl.has_el3 && l3_deny)
      kind = ctl.undef_not_trap ? RES_UNDEF : RES_TRAP3;
  end
endmodule

// File: rtl/grpcfg_word_store.sv
module grpcfg_word_store #(
  parameter int NUM_UNITS = 4,
  parameter int SEL_W     = 3,
  parameter int DATA_W    = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SEL_W-1:0]  wunit,
  input  logic              wreg,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  runit,
  input  logic              rreg,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH  = 2 * NUM_UNITS;
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              oor_q;
  logic              w_in, r_in;
  logic [ADDR_W-1:0] waddr, raddr;

  always_comb begin
    w_in  = int'(wunit) < NUM_UNITS;
    r_in  = int'(runit) < NUM_UNITS;
    waddr = w_in ? ADDR_W'({wunit, wreg}) : '0;
    raddr = r_in ? ADDR_W'({runit, rreg}) : '0;
  end

  always_ff @(posedge clk) begin
    if (we && w_in)
      mem[waddr] <= wdata;
    rd_q  <= mem[raddr];
    oor_q <= !r_in;
  end

  assign rdata = oor_q ? '0 : rd_q;
endmodule

// File: rtl/sysreg_grpcfg_gate.sv
module sysreg_grpcfg_gate
  import sysreg_grpcfg_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int SEL_W     = 3,
  localparam int PERM_W   = 2 * (2**SEL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_unit,
  input  logic              cfg_reg,
  input  logic [63:0]       cfg_wdata,
  input  logic              acc_valid,
  input  logic [1:0]        acc_op0,
  input  logic [2:0]        acc_op1,
  input  logic [3:0]        acc_crn,
  input  logic [3:0]        acc_crm,
  input  logic [2:0]        acc_op2,
  input  logic [1:0]        acc_lvl,
  input  logic [SEL_W-1:0]  acc_unit,
  input  logic              has_el3,
  input  logic              el2_active,
  input  logic              undef_prio,
  input  logic              undef_not_trap,
  input  logic              el3_unit_en,
  input  logic              el2_unit_en,
  input  logic              fg_trap_impl,
  input  logic              fg_el3_en,
  input  logic              fg_read_allow,
  input  logic [PERM_W-1:0] el2_perm,
  input  logic [PERM_W-1:0] el3_perm,
  output logic              res_valid,
  output logic              res_undef,
  output logic              res_trap_l2,
  output logic              res_trap_l3,
  output logic              res_ok,
  output logic [5:0]        res_class,
  output logic [63:0]       res_data
);
  logic       hit, word_sel, fire;
  gate_ctl_t  ctl;
  res_kind_e  kind;
  logic [63:0] store_q;

  assign ctl = '{has_el3: has_el3, el2_active: el2_active, undef_prio: undef_prio,
                 undef_not_trap: undef_not_trap, el3_unit_en: el3_unit_en,
                 el2_unit_en: el2_unit_en, fg_trap_impl: fg_trap_impl,
                 fg_el3_en: fg_el3_en, fg_read_allow: fg_read_allow};

  grpcfg_enc_match u_match (
    .op0(acc_op0), .op1(acc_op1), .crn(acc_crn), .crm(acc_crm), .op2(acc_op2),
    .hit(hit), .word_sel(word_sel)
  );

  grpcfg_priv_chain #(.SEL_W(SEL_W)) u_chain (
    .lvl(acc_lvl), .unit(acc_unit), .ctl(ctl),
    .el2_perm(el2_perm), .el3_perm(el3_perm), .kind(kind)
  );

  grpcfg_word_store #(.NUM_UNITS(NUM_UNITS), .SEL_W(SEL_W), .DATA_W(WORD_W)) u_store (
    .clk(clk), .we(cfg_we), .wunit(cfg_unit), .wreg(cfg_reg), .wdata(cfg_wdata),
    .runit(acc_unit), .rreg(word_sel), .rdata(store_q)
  );

  assign fire = acc_valid && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_undef   <= 1'b0;
      res_trap_l2 <= 1'b0;
      res_trap_l3 <= 1'b0;
      res_ok      <= 1'b0;
      res_class   <= '0;
    end else begin
      res_valid   <= fire;
      res_undef   <= fire && (kind == RES_UNDEF);
      res_trap_l2 <= fire && (kind == RES_TRAP2);
      res_trap_l3 <= fire && (kind == RES_TRAP3);
      res_ok      <= fire && (kind == RES_OK);
      res_class   <= (fire && (kind == RES_TRAP2 || kind == RES_TRAP3)) ? TRAP_CLASS : '0;
    end
  end

  assign res_data = res_ok ? store_q : '0;

  assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $onehot({res_undef, res_trap_l2, res_trap_l3, res_ok}));
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ({res_undef, res_trap_l2, res_trap_l3, res_ok} == 4'b0000));
  assert_class_R9: assert property (@(posedge clk) disable iff (rst)
    (res_class != 6'h0) |-> ((res_trap_l2 || res_trap_l3) && res_class == 6'h18));
  assert_nohit_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !(acc_valid && hit)) |-> !res_valid);
  assert_lvl0_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && acc_valid && hit && acc_lvl == 2'd0) |-> res_undef);
  assert_lvl3_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && acc_valid && hit && acc_lvl == 2'd3) |-> res_ok);
  assert_oor_zero_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && int'(acc_unit) >= NUM_UNITS) |-> (res_data == 64'h0));
endmodule

// File: tb/sysreg_grpcfg_gate_tb.sv
module sysreg_grpcfg_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 4;
  localparam int SW = 3;
  localparam int PW = 2 * (2**SW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_reg = 1'b0;
  logic [SW-1:0] cfg_unit = '0;
  logic [63:0] cfg_wdata = '0;
  logic acc_valid = 1'b0;
  logic [1:0] op0 = '0; logic [2:0] op1 = '0; logic [3:0] crn = '0, crm = '0;
  logic [2:0] op2 = '0; logic [1:0] lvl = '0; logic [SW-1:0] unit = '0;
  logic has_el3 = 0, el2_active = 0, undef_prio = 0, undef_not_trap = 0;
  logic el3_unit_en = 0, el2_unit_en = 0, fg_trap_impl = 0, fg_el3_en = 0, fg_read_allow = 0;
  logic [PW-1:0] el2_perm = '0, el3_perm = '0;
  logic res_valid, res_undef, res_trap_l2, res_trap_l3, res_ok;
  logic [5:0] res_class;
  logic [63:0] res_data;

  int vectors = 0, misses = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_grpcfg_gate #(.NUM_UNITS(NU), .SEL_W(SW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_unit(cfg_unit), .cfg_reg(cfg_reg),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_op0(op0), .acc_op1(op1),
    .acc_crn(crn), .acc_crm(crm), .acc_op2(op2), .acc_lvl(lvl), .acc_unit(unit),
    .has_el3(has_el3), .el2_active(el2_active), .undef_prio(undef_prio),
    .undef_not_trap(undef_not_trap), .el3_unit_en(el3_unit_en), .el2_unit_en(el2_unit_en),
    .fg_trap_impl(fg_trap_impl), .fg_el3_en(fg_el3_en), .fg_read_allow(fg_read_allow),
    .el2_perm(el2_perm), .el3_perm(el3_perm), .res_valid(res_valid), .res_undef(res_undef),
    .res_trap_l2(res_trap_l2), .res_trap_l3(res_trap_l3), .res_ok(res_ok),
    .res_class(res_class), .res_data(res_data)
  );

  function automatic logic [63:0] pattern(int u, int r);
    logic [63:0] w;
    for (int m = 0; m < 8; m++) w[8*m +: 8] = 8'((u * 16 + r * 8 + m + 1) * 7);
    return w;
  endfunction

  // Permission word: the target field carries the verdict, the others the opposite.
  function automatic logic [PW-1:0] mk_perm(int s, bit allow, int n);
    logic [PW-1:0] w;
    w = allow ? '0 : '1;
    w[2*s +: 2] = allow ? 2'((n % 3) + 1) : 2'b00;
    return w;
  endfunction

  // Outcome code: 0 ok, 1 undef, 2 trap to level 2, 3 trap to level 3.
  function automatic int expect_kind(int l, logic [8:0] f, bit p2, bit p3, output string tag);
    bit e3, a2, up, ut, pe3, pe2, fi, fe3, fr, deny3;
    {e3, a2, up, ut, pe3, pe2, fi, fe3, fr} = f;
    deny3 = !pe3 || !p3;
    if (l == 0) begin tag = "R3"; return 1; end
    if (l == 3) begin tag = "R4"; return 0; end
    if (e3 && up && deny3) begin tag = "R5"; return 1; end
    if (l == 1 && a2) begin
      tag = "R6";
      if (fi && ((e3 && !fe3) || !fr)) return 2;
      if (!pe2) return 2;
      if (!p2) return 2;
    end
    if (e3 && deny3) begin tag = "R7"; return ut ? 1 : 3; end
    tag = "R2";
    return 0;
  endfunction

  task automatic set_enc_ok(bit wsel);
    op0 = 2'b10; op1 = 3'b000; crn = 4'b1001; crm = 4'b1101; op2 = {2'b00, wsel};
  endtask

  task automatic check(string tag, bit ev, int ek, logic [63:0] ed);
    logic [3:0] eo;
    logic [5:0] ec;
    @(posedge clk); #1;
    vectors++;
    eo = ev ? (4'b1 << ek) : 4'b0;
    ec = (ev && (ek == 2 || ek == 3)) ? 6'h18 : 6'h0;
    if (res_valid !== ev || {res_trap_l3, res_trap_l2, res_undef, res_ok} !== eo ||
        res_class !== ec || res_data !== ed) begin
      misses++;
      $display("FAIL %s: got v=%b o=%b c=%h d=%h, want v=%b o=%b c=%h d=%h", tag,
               res_valid, {res_trap_l3, res_trap_l2, res_undef, res_ok}, res_class, res_data,
               ev, eo, ec, ed);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", 1'b0, 0, 64'h0);
    @(negedge clk); rst = 1'b0;
    for (int u = 0; u < NU; u++)
      for (int r = 0; r < 2; r++) begin
        @(negedge clk);
        cfg_we = 1; cfg_unit = SW'(u); cfg_reg = r[0]; cfg_wdata = pattern(u, r);
      end
    @(negedge clk); cfg_we = 0;

    // R1: encoding mismatches and idle cycles produce nothing
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      set_enc_ok(1'b0); lvl = 2'd3; unit = '0; acc_valid = 1;
      case (k)
        0: op0 = 2'b11;
        1: op1 = 3'b001;
        2: crn = 4'b1000;
        3: crm = 4'b1100;
        4: op2 = 3'b010;
        default: acc_valid = 0;
      endcase
      check("R1", 1'b0, 0, 64'h0);
    end

    // R2..R10: full sweep of level, flags and permission verdicts
    for (int l = 0; l < 4; l++)
      for (int f = 0; f < 512; f++)
        for (int p = 0; p < 4; p++) begin
          int n, s, r, ek;
          string tag;
          logic [63:0] ed;
          n = (l * 512 + f) * 4 + p;
          s = n % 8;
          r = (n / 8) % 2;
          @(negedge clk);
          acc_valid = 1; set_enc_ok(r[0]); lvl = 2'(l); unit = SW'(s);
          {has_el3, el2_active, undef_prio, undef_not_trap, el3_unit_en, el2_unit_en,
           fg_trap_impl, fg_el3_en, fg_read_allow} = 9'(f);
          el2_perm = mk_perm(s, p[0], n);   // R8 field at bits 2s+1:2s
          el3_perm = mk_perm(s, p[1], n + 1);
          ek = expect_kind(l, 9'(f), p[0], p[1], tag);
          ed = (ek == 0 && s < NU) ? pattern(s, r) : 64'h0;
          if (ek == 0 && s >= NU) tag = "R10";
          check(tag, 1'b1, ek, ed);
        end

    @(negedge clk); acc_valid = 0;
    check("R1", 1'b0, 0, 64'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule